// File: doc/BRIEF.md
# Word-Mask Permute Control Generator

This block turns a 128-bit word mask into a 128-bit permute control vector for a downstream byte-permute unit. The mask is split into four 32-bit words, and a word takes part when its most significant bit is set. A running count of the selected words is turned into byte lane indices. Two modes expand the selected source words into the positions their mask words occupy. The other two compress the selected words into a packed run. Each pair has a big-endian and a little-endian form. Lanes left unselected by an expand mode point into a second permute source, at indices 16 to 31.

The block also decodes the 32-bit instruction word. It extracts the target and mask register numbers, rejects immediate values outside the four defined modes, and raises an unavailable fault when the vector facility is switched off. A request is accepted in the cycle when `req_valid` is high and the instruction matches. The registered result and its flags appear one cycle later, together with a one-cycle `rsp_valid` pulse.

Top module: `pcvg_top`

## Requirements
- R1: A request is accepted only when the instruction bits [31:26] equal 60 and bits [10:1] equal 948 (bit 31 is the most significant). Any other instruction produces no `rsp_valid`.
- R2: `rsp_valid` rises in the cycle after an accepted request and stays high for that one cycle only, unless another request is accepted.
- R3: Mask word w (w = 0..3) occupies bits [127-32w : 96-32w]. The word is selected when its top bit, mask[127-32w], is 1. The other 31 bits of each word have no effect on the result.
- R4: Immediate (bits [20:16]) 0 selects big-endian expand. Output byte b sits at bits [127-8b : 120-8b], and word w holds bytes 4w..4w+3. If word w is selected and j selected words precede it, byte 4w+k = 4j+k. Otherwise byte 4w+k = 16+4w+k.
- R5: Immediate 1 selects big-endian compress. The n-th selected word m (counting from word 0, n from 0) fills output word n with byte 4n+k = 4m+k. Output words at and beyond the selected count are zero.
- R6: Immediate 2 selects little-endian expand. If word w is selected and j selected words lie above it (indices greater than w), byte 4w+k = 4j+3-k. Otherwise byte 4w+k = 16+4(3-w)+3-k.
- R7: Immediate 3 selects little-endian compress. If word m is selected and j selected words lie above it, output word 3-j has byte 4(3-j)+k = 4(3-m)+3-k. The lowest-numbered words that receive no source word are zero.
- R8: An immediate from 4 to 31 sets `illegal_form` with the response and gives an all-zero `pcv`.
- R9: If `facility_en` is 0 at acceptance, the response carries `fault_unavail` = 1, `illegal_form` = 0 and an all-zero `pcv`. The fault takes priority over an illegal immediate.
- R10: With the response, `tgt_reg` = {instr[0], instr[25:21]} (32 times the extension bit plus the 5-bit field), and `src_reg` = {1, instr[15:11]} (the mask register field plus 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| mask_vec | input | 128 | Word mask vector |
| facility_en | input | 1 | Vector facility enable |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| pcv | output | 128 | Permute control vector |
| tgt_reg | output | 6 | Target register number |
| src_reg | output | 6 | Mask register number |
| fault_unavail | output | 1 | Facility unavailable fault |
| illegal_form | output | 1 | Reserved immediate used |

## Verification
The bench runs all 16 selection patterns in every mode, with the low 31 bits of each mask word filled with noise. A design that tested the wrong bit, or counted from the wrong end, shows wrong lane indices for asymmetric patterns such as 0001 and 1000. The bench also covers the all-clear and all-set patterns. In the compress modes these show whether the unused words are zeroed on the correct side, and in the expand modes whether unselected lanes take second-source indices. Reserved immediates, a disabled facility combined with a reserved immediate, and near-miss opcodes are each driven. A design with the wrong priority or decode would then return a non-zero vector, the wrong flag, or a spurious response.

// File: rtl/pcvg_pkg.sv
package pcvg_pkg;
  typedef enum logic [1:0] {
    PM_BE_EXPAND   = 2'd0,
    PM_BE_COMPRESS = 2'd1,
    PM_LE_EXPAND   = 2'd2,
    PM_LE_COMPRESS = 2'd3
  } pm_mode_t;

  localparam int unsigned PRIMARY_OP = 60;
  localparam int unsigned EXT_OP     = 948;
endpackage

// File: rtl/pcvg_decode.sv
module pcvg_decode
  import pcvg_pkg::*;
(
  input  logic [31:0] instr,
  output logic        hit,
  output logic [4:0]  imm,
  output logic [5:0]  tgt,
  output logic [5:0]  src
);
  logic [5:0] prim;
  logic [9:0] ext;

  always_comb begin
    prim = instr[31:26];
    ext  = instr[10:1];
    hit  = (prim == 6'(PRIMARY_OP)) && (ext == 10'(EXT_OP));
    imm  = instr[20:16];
    tgt  = {instr[0], instr[25:21]};
    src  = {1'b1, instr[15:11]};
  end
endmodule

// File: rtl/pcvg_count.sv
module pcvg_count #(
  parameter int NW = 4,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic [NW-1:0]    sel,
  output logic [NW*CW-1:0] below_flat,
  output logic [NW*CW-1:0] above_flat
);
  logic [CW-1:0] below [NW];
  logic [CW-1:0] above [NW];

  assign below[0]    = '0;
  assign above[NW-1] = '0;

  genvar g;
  generate
    for (g = 1; g < NW; g++) begin : g_chain
      assign below[g]        = below[g-1] + CW'(sel[g-1]);
      assign above[NW-1-g]   = above[NW-g] + CW'(sel[NW-g]);
    end
    for (g = 0; g < NW; g++) begin : g_pack
      assign below_flat[g*CW +: CW] = below[g];
      assign above_flat[g*CW +: CW] = above[g];
    end
  endgenerate
endmodule

// File: rtl/pcvg_lanes.sv
module pcvg_lanes
  import pcvg_pkg::*;
#(
  parameter int NW  = 4,
  parameter int BPW = 4,
  parameter int IW  = 8,
  localparam int CW  = $clog2(NW + 1),
  localparam int NB  = NW * BPW,
  localparam int SEC = NB
) (
  input  logic [NW-1:0]    sel,
  input  pm_mode_t         mode,
  input  logic [NW*CW-1:0] below_flat,
  input  logic [NW*CW-1:0] above_flat,
  output logic [NB*IW-1:0] ctl
);
  logic [IW-1:0] lane [NW][BPW];
  int            below [NW];
  int            above [NW];

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      below[w] = int'(below_flat[w*CW +: CW]);
      above[w] = int'(above_flat[w*CW +: CW]);
    end
  end

  always_comb begin
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < BPW; k++)
        lane[w][k] = '0;
    case (mode)
      PM_BE_EXPAND: begin
        for (int w = 0; w < NW; w++)
          for (int k = 0; k < BPW; k++)
            lane[w][k] = sel[w] ? IW'(BPW * below[w] + k)
                                : IW'(SEC + BPW * w + k);
      end
      PM_BE_COMPRESS: begin
        for (int m = 0; m < NW; m++)
          if (sel[m])
            for (int k = 0; k < BPW; k++)
              lane[below[m]][k] = IW'(BPW * m + k);
      end
      PM_LE_EXPAND: begin
        for (int w = 0; w < NW; w++)
          for (int k = 0; k < BPW; k++)
            lane[w][k] = sel[w] ? IW'(BPW * above[w] + BPW - 1 - k)
                                : IW'(SEC + BPW * (NW - 1 - w) + BPW - 1 - k);
      end
      PM_LE_COMPRESS: begin
        for (int m = 0; m < NW; m++)
          if (sel[m])
            for (int k = 0; k < BPW; k++)
              lane[NW - 1 - above[m]][k] = IW'(BPW * (NW - 1 - m) + BPW - 1 - k);
      end
      default: ;
    endcase
  end

  genvar gw, gk;
  generate
    for (gw = 0; gw < NW; gw++) begin : g_word
      for (gk = 0; gk < BPW; gk++) begin : g_byte
        assign ctl[(NB - 1 - (gw * BPW + gk)) * IW +: IW] = lane[gw][gk];
      end
    end
  endgenerate
endmodule

// File: rtl/pcvg_top.sv
module pcvg_top
  import pcvg_pkg::*;
#(
  parameter int NW  = 4,
  parameter int BPW = 4,
  parameter int IW  = 8,
  localparam int WW = BPW * 8,
  localparam int VW = NW * WW,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   instr,
  input  logic [VW-1:0] mask_vec,
  input  logic          facility_en,
  output logic          rsp_valid,
  output logic [VW-1:0] pcv,
  output logic [5:0]    tgt_reg,
  output logic [5:0]    src_reg,
  output logic          fault_unavail,
  output logic          illegal_form
);
  logic            hit;
  logic [4:0]      imm;
  logic [5:0]      tgt_d, src_d;
  logic [NW-1:0]   sel;
  logic [NW*CW-1:0] below_flat, above_flat;
  logic [VW-1:0]   ctl;
  logic            accept;
  logic            nxt_fault, nxt_ill;
  logic [VW-1:0]   nxt_pcv;
  logic            unused_mask_low;

  pcvg_decode u_dec (
    .instr (instr),
    .hit   (hit),
    .imm   (imm),
    .tgt   (tgt_d),
    .src   (src_d)
  );

  genvar g;
  generate
    for (g = 0; g < NW; g++) begin : g_sel
      assign sel[g] = mask_vec[(NW - g) * WW - 1];
    end
  endgenerate
  assign unused_mask_low = ^mask_vec;

  pcvg_count #(.NW(NW)) u_cnt (
    .sel        (sel),
    .below_flat (below_flat),
    .above_flat (above_flat)
  );

  pcvg_lanes #(.NW(NW), .BPW(BPW), .IW(IW)) u_lanes (
    .sel        (sel),
    .mode       (pm_mode_t'(imm[1:0])),
    .below_flat (below_flat),
    .above_flat (above_flat),
    .ctl        (ctl)
  );

  always_comb begin
    accept    = req_valid && hit;
    nxt_fault = !facility_en;
    nxt_ill   = facility_en && (imm[4:2] != 3'b000);
    nxt_pcv   = (nxt_fault || nxt_ill) ? '0 : ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcv           <= '0;
      tgt_reg       <= '0;
      src_reg       <= '0;
      fault_unavail <= 1'b0;
      illegal_form  <= 1'b0;
    end else if (accept) begin
      pcv           <= nxt_pcv;
      tgt_reg       <= tgt_d;
      src_reg       <= src_d;
      fault_unavail <= nxt_fault;
      illegal_form  <= nxt_ill;
    end
  end
endmodule

// File: rtl/pcvg_checker.sv
module pcvg_checker #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [31:0]   instr,
  input logic          facility_en,
  input logic          rsp_valid,
  input logic [VW-1:0] pcv,
  input logic [5:0]    tgt_reg,
  input logic [5:0]    src_reg,
  input logic          fault_unavail,
  input logic          illegal_form
);
  logic took;
  assign took = req_valid && (instr[31:26] == 6'd60) && (instr[10:1] == 10'd948);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> !rsp_valid);

  assert_fault_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !facility_en) |=> (fault_unavail && !illegal_form && pcv == '0));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && illegal_form) |-> (pcv == '0));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({fault_unavail, illegal_form}));

  assert_reg_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (tgt_reg == {$past(instr[0]), $past(instr[25:21])}
              && src_reg == {1'b1, $past(instr[15:11])}));
endmodule

bind pcvg_top pcvg_checker #(.VW(VW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .instr         (instr),
  .facility_en   (facility_en),
  .rsp_valid     (rsp_valid),
  .pcv           (pcv),
  .tgt_reg       (tgt_reg),
  .src_reg       (src_reg),
  .fault_unavail (fault_unavail),
  .illegal_form  (illegal_form)
);

// File: tb/tb_pcvg_top.sv
module tb_pcvg_top;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  instr;
  logic [127:0] mask_vec;
  logic         facility_en;
  logic         rsp_valid;
  logic [127:0] pcv;
  logic [5:0]   tgt_reg, src_reg;
  logic         fault_unavail, illegal_form;

  int n_cmp = 0;
  int n_bad = 0;

  pcvg_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .mask_vec(mask_vec), .facility_en(facility_en), .rsp_valid(rsp_valid),
    .pcv(pcv), .tgt_reg(tgt_reg), .src_reg(src_reg),
    .fault_unavail(fault_unavail), .illegal_form(illegal_form)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic tx, input logic [4:0] t,
                                     input logic [4:0] im, input logic [4:0] b);
    return {6'd60, t, im, b, 10'd948, tx};
  endfunction

  function automatic logic [127:0] mk_mask(input logic [3:0] s);
    logic [127:0] v;
    for (int w = 0; w < 4; w++)
      v[127 - 32*w -: 32] = {s[w], 31'h2B5C_7E19 ^ 31'(w * 32'h0101_0103)};
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [3:0] s, input int md);
    logic [7:0] e [16];
    logic [127:0] v;
    int j = 0;
    for (int b = 0; b < 16; b++) e[b] = 8'd0;
    for (int i = 0; i < 4; i++) begin
      case (md)
        0: if (s[i]) begin
             for (int k = 0; k < 4; k++) e[4*i+k] = 8'(4*j + k);
             j++;
           end else for (int k = 0; k < 4; k++) e[4*i+k] = 8'(16 + 4*i + k);
        1: if (s[i]) begin
             for (int k = 0; k < 4; k++) e[4*j+k] = 8'(4*i + k);
             j++;
           end
        2: if (s[3-i]) begin
             for (int k = 0; k < 4; k++) e[4*(3-i)+3-k] = 8'(4*j + k);
             j++;
           end else for (int k = 0; k < 4; k++) e[4*(3-i)+3-k] = 8'(16 + 4*i + k);
        default: if (s[3-i]) begin
             for (int k = 0; k < 4; k++) e[4*(3-j)+3-k] = 8'(4*i + k);
             j++;
           end
      endcase
    end
    for (int b = 0; b < 16; b++) v[127 - 8*b -: 8] = e[b];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [127:0] m, input logic fe);
    @(negedge clk);
    req_valid = 1'b1; instr = ins; mask_vec = m; facility_en = fe;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 reset valid", 128'(rsp_valid), 128'(0));
    check("R2 reset pcv", pcv, '0);
    check("R9 reset flags", 128'({fault_unavail, illegal_form}), 128'(0));
  endtask

  task automatic t_mode(input int md, input string req);
    for (int p = 0; p < 16; p++) begin
      issue(mk(1'b0, 5'd3, 5'(md), 5'd7), mk_mask(4'(p)), 1'b1);
      check(req, pcv, model(4'(p), md));
      check("R3 flags", 128'({rsp_valid, fault_unavail, illegal_form}), 128'(3'b100));
    end
  endtask

  task automatic t_pulse;
    issue(mk(1'b1, 5'd9, 5'd0, 5'd2), mk_mask(4'b1010), 1'b1);
    check("R2 valid high", 128'(rsp_valid), 128'(1));
    @(negedge clk);
    check("R2 valid drops", 128'(rsp_valid), 128'(0));
  endtask

  task automatic t_fields;
    issue(mk(1'b1, 5'd21, 5'd1, 5'd13), mk_mask(4'b0110), 1'b1);
    check("R10 tgt", 128'(tgt_reg), 128'(6'd53));
    check("R10 src", 128'(src_reg), 128'(6'd45));
  endtask

  task automatic t_illegal;
    for (int im = 4; im < 32; im += 9) begin
      issue(mk(1'b0, 5'd1, 5'(im), 5'd1), mk_mask(4'b1111), 1'b1);
      check("R8 pcv zero", pcv, '0);
      check("R8 flags", 128'({rsp_valid, fault_unavail, illegal_form}), 128'(3'b101));
    end
  endtask

  task automatic t_fault;
    issue(mk(1'b0, 5'd4, 5'd0, 5'd5), mk_mask(4'b1111), 1'b0);
    check("R9 pcv zero", pcv, '0);
    check("R9 flags", 128'({rsp_valid, fault_unavail, illegal_form}), 128'(3'b110));
    issue(mk(1'b0, 5'd4, 5'd6, 5'd5), mk_mask(4'b1111), 1'b0);
    check("R9 priority", 128'({rsp_valid, fault_unavail, illegal_form}), 128'(3'b110));
  endtask

  task automatic t_miss;
    logic [31:0] bad;
    bad = mk(1'b0, 5'd2, 5'd0, 5'd3);
    bad[31:26] = 6'd61;
    issue(bad, mk_mask(4'b0001), 1'b1);
    check("R1 opcode miss", 128'(rsp_valid), 128'(0));
    bad = mk(1'b0, 5'd2, 5'd0, 5'd3);
    bad[10:1] = 10'd947;
    issue(bad, mk_mask(4'b0001), 1'b1);
    check("R1 xo miss", 128'(rsp_valid), 128'(0));
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; instr = '0; mask_vec = '0; facility_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(0, "R4 be expand");
    t_mode(1, "R5 be compress");
    t_mode(2, "R6 le expand");
    t_mode(3, "R7 le compress");
    t_pulse();
    t_fields();
    t_illegal();
    t_fault();
    t_miss();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule